// File: doc/BRIEF.md
# Flag-producing integer multiplier

This block multiplies two W-bit integers in one of three ways, chosen by a 2-bit operation code. The two widening forms give a full 2W-bit product, unsigned or signed. The high half of the product drives `hi` and the low half drives `lo`. The third form is a signed multiply that keeps only the low W bits. It writes `lo` and leaves `hi` holding its previous value. A mask tells the surrounding register file which of the two result registers to write back.

Every operation also produces six arithmetic status flags. Carry and overflow mark a product that does not fit in W bits. The sign flag and the parity flag are taken from the low half. The zero flag and the adjust flag are always cleared.

A one-cycle `start` pulse launches an operation. `done` pulses exactly two clock cycles later. At that point the results, the mask and the flags are registered. They then hold steady until the next completion. A new operation may start on every cycle. W may be 16, 32 or 64.

Top module: `mulflag_unit`

## Requirements
- R1: Op code 0 (unsigned) and op code 1 (signed) drive the upper W bits of the 2W-bit product onto `hi` and the lower W bits onto `lo`, with `wr_mask` = 2'b11 (bit 0 means lo written, bit 1 means hi written).
- R2: For op code 0, carry and overflow are both set when the upper half of the product is nonzero, and both are clear otherwise. For example, all-ones times all-ones gives hi = all-ones minus 1 and lo = 1, with CF and OF set.
- R3: For op codes 1 and 2, carry and overflow are both set exactly when the upper half of the signed product differs from the sign extension of the lower half. For example, 2 times the largest positive value sets both flags, and the most negative value times 2 gives lo = 0 and hi = all-ones with CF, OF and PF set.
- R4: The sign flag equals bit W-1 of the low half. The parity flag is set when bits 7:0 of the low half hold an even number of ones.
- R5: The zero flag and the adjust flag are 0 after every operation, even when the low half is zero.
- R6: Op code 2 (signed truncating) updates only `lo` with the low W bits of the signed product. `hi` keeps its previous value, `wr_mask` = 2'b01, and the flags follow R3 and R4.
- R7: Swapping `a` and `b` gives identical `hi`, `lo` and `flags`.
- R8: `done` is a single-cycle pulse two clock cycles after a start. The outputs change only in a cycle where `done` is high.
- R9: Op code 3 is reserved. A start with op code 3 produces no `done` and leaves every output unchanged.
- R10: After reset, `hi`, `lo`, `flags` and `wr_mask` are 0 and `done` is low.
- R11: `flags` bit order is bit 0 CF, bit 1 PF, bit 2 AF, bit 3 ZF, bit 4 SF, bit 5 OF.
- R12: Starts on consecutive cycles each complete, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 2 | 0 unsigned widening, 1 signed widening, 2 signed truncating, 3 reserved |
| a | input | W | First operand |
| b | input | W | Second operand |
| hi | output | W | Upper product half |
| lo | output | W | Lower product half |
| wr_mask | output | 2 | Result registers written: bit 0 lo, bit 1 hi |
| flags | output | 6 | {OF, SF, ZF, AF, PF, CF} |
| done | output | 1 | Result valid pulse |

## Verification
If the captured product or the captured op code is wrong, the error shows at the ports in the cycle `done` rises, exactly two cycles after the start. It appears as a bad result half, a bad flag or a wrong mask. A wrong valid bit in the product stage shows up at once as a missing or extra `done` pulse. A truncating operation that writes `hi` when it should not is caught at the next completion. A stale value left from an earlier operation is caught the same way. The reference model runs alongside the design and checks every port on every clock. Directed checks are added for sign boundaries, swapped operands and reserved codes.

// File: rtl/mulflag_unit.sv
module mulflag_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic [1:0]   wr_mask,
  output logic [5:0]   flags,
  output logic         done
);
  localparam int PW = 2 * W;
  localparam logic [1:0] OP_UMUL  = 2'd0;
  localparam logic [1:0] OP_TRUNC = 2'd2;
  localparam logic [1:0] OP_RSVD  = 2'd3;

  if (W != 16 && W != 32 && W != 64) begin : g_bad_width
    $error("mulflag_unit: W must be 16, 32 or 64");
  end

  logic [PW-1:0] uprod, sprod;
  assign uprod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign sprod = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};

  logic          s1_v;
  logic [1:0]    s1_op;
  logic [PW-1:0] s1_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_op   <= OP_UMUL;
      s1_prod <= '0;
    end else begin
      s1_v <= start && (op != OP_RSVD);
      if (start) begin
        s1_op   <= op;
        s1_prod <= (op == OP_UMUL) ? uprod : sprod;
      end
    end
  end

  logic [W-1:0] p_lo, p_hi;
  logic         ovf, par;
  assign p_lo = s1_prod[W-1:0];
  assign p_hi = s1_prod[PW-1:W];
  assign ovf  = (s1_op == OP_UMUL) ? (|p_hi) : (p_hi != {W{p_lo[W-1]}});
  assign par  = ~^p_lo[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi      <= '0;
      lo      <= '0;
      wr_mask <= 2'b00;
      flags   <= 6'd0;
      done    <= 1'b0;
    end else begin
      done <= s1_v;
      if (s1_v) begin
        lo      <= p_lo;
        flags   <= {ovf, p_lo[W-1], 1'b0, 1'b0, par, ovf};
        wr_mask <= (s1_op == OP_TRUNC) ? 2'b01 : 2'b11;
        if (s1_op != OP_TRUNC) hi <= p_hi;
      end
    end
  end
endmodule

// File: rtl/mulflag_unit_chk.sv
module mulflag_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo,
  input logic [1:0]   wr_mask,
  input logic [5:0]   flags,
  input logic         done
);
  AST_AF_ZF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[2] == 1'b0 && flags[3] == 1'b0)); // R5

  AST_CF_MATCHES_OF: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[0] == flags[5])); // R2

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start, 2) && $past(op, 2) != 2'd3) |-> done); // R8

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(start, 2) && $past(op, 2) != 2'd3)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(lo) && $stable(hi) && $stable(flags) && $stable(wr_mask))); // R8

  AST_TRUNC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_mask == (($past(op, 2) == 2'd2) ? 2'b01 : 2'b11))); // R6

  AST_TRUNC_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_mask == 2'b01) |-> $stable(hi)); // R6
endmodule

bind mulflag_unit mulflag_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .hi(hi), .lo(lo),
  .wr_mask(wr_mask), .flags(flags), .done(done)
);

// File: tb/sim_mulflag_unit.sv
module sim_mulflag_unit;
  localparam int W = 32;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] hi, lo;
  logic [1:0] wr_mask;
  logic [5:0] flags;
  logic done;

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_on = 1'b0;

  always #(TCLK/2) clk = ~clk;

  mulflag_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
    .hi(hi), .lo(lo), .wr_mask(wr_mask), .flags(flags), .done(done)
  );

  task automatic chk(input string tag, input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model(input logic [1:0] mop, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [W-1:0] hold_hi, output logic [W-1:0] eh,
                       output logic [W-1:0] el, output logic [5:0] ef, output logic [1:0] em);
    longint unsigned pu;
    longint ps;
    logic [63:0] p;
    bit ov;
    pu = {32'd0, x} * {32'd0, y};
    ps = longint'(int'(x)) * longint'(int'(y));
    if (mop == 2'd0) begin
      p  = pu;
      ov = (pu >> 32) != 0;
    end else begin
      p  = ps;
      ov = ps != longint'(int'(ps[31:0]));
    end
    el = p[31:0];
    eh = (mop == 2'd2) ? hold_hi : p[63:32];
    em = (mop == 2'd2) ? 2'b01 : 2'b11;
    ef = {ov, el[31], 1'b0, 1'b0, ($countones(el[7:0]) % 2) == 0, ov};
  endtask

  logic m1_v = 1'b0;
  logic [1:0] m1_op;
  logic [W-1:0] m1_a, m1_b;
  logic [W-1:0] e_hi = '0, e_lo = '0;
  logic [5:0] e_fl = '0;
  logic [1:0] e_mk = '0;
  logic e_done = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m1_v = 0; e_hi = '0; e_lo = '0; e_fl = '0; e_mk = '0; e_done = 0;
    end else begin
      e_done = m1_v;
      if (m1_v) model(m1_op, m1_a, m1_b, e_hi, e_hi, e_lo, e_fl, e_mk);
      m1_v = start && op != 2'd3;
      if (start) begin m1_op = op; m1_a = a; m1_b = b; end
    end
    if (cyc > 50000) begin
      fails++; checks++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below 50000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 done", done, e_done);
      chk("R1/R6 lo", lo, e_lo);
      chk("R1/R6 hi", hi, e_hi);
      chk("R6 wr_mask", wr_mask, e_mk);
      chk("R2/R3/R4/R5 flags", flags, e_fl);
    end
  end

  logic [W-1:0] r_hi, r_lo;
  logic [5:0] r_fl;
  logic [1:0] r_mk;
  logic r_done;

  task automatic run(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk); start = 1; op = o; a = x; b = y;
    @(negedge clk); start = 0;
    @(negedge clk);
    r_hi = hi; r_lo = lo; r_fl = flags; r_mk = wr_mask; r_done = done;
  endtask

  initial begin
    logic [W-1:0] s_hi, s_lo;
    logic [5:0] s_fl;
    repeat (3) @(negedge clk);
    chk("R10 reset hi", hi, 0);
    chk("R10 reset lo", lo, 0);
    chk("R10 reset flags", flags, 0);
    chk("R10 reset mask", wr_mask, 0);
    chk("R10 reset done", done, 0);
    rst_n = 1; cmp_on = 1;

    run(2'd0, 32'd2, 32'd2);
    chk("R1 lo 2*2", r_lo, 4); chk("R1 hi 2*2", r_hi, 0);
    chk("R1 mask", r_mk, 2'b11); chk("R8 done pulse", r_done, 1);

    run(2'd0, 32'hffffffff, 32'hffffffff);
    chk("R2 hi", r_hi, 32'hfffffffe); chk("R2 lo", r_lo, 1);
    chk("R11 flags CF|OF", r_fl, 6'h21);

    run(2'd1, 32'd2, 32'h7fffffff);
    chk("R3 lo", r_lo, 32'hfffffffe); chk("R3 hi", r_hi, 0);
    chk("R3 flags", r_fl, 6'h31);

    run(2'd1, 32'h80000000, 32'd2);
    chk("R3 minneg lo", r_lo, 0); chk("R3 minneg hi", r_hi, 32'hffffffff);
    chk("R3 minneg flags", r_fl, 6'h23);
    chk("R5 zf clear on zero lo", r_fl[3], 0);

    run(2'd1, 32'd1, 32'h7fffffff);
    chk("R4 parity set", r_fl, 6'h02);
    run(2'd1, 32'hfffffffc, 32'd3);
    chk("R4 sign set", r_fl, 6'h10); chk("R4 hi", r_hi, 32'hffffffff);

    run(2'd0, 32'hffffffff, 32'hffffffff);
    run(2'd2, 32'h80000000, 32'd2);
    chk("R6 trunc lo", r_lo, 0); chk("R6 trunc hi kept", r_hi, 32'hfffffffe);
    chk("R6 trunc mask", r_mk, 2'b01); chk("R6 trunc flags", r_fl, 6'h23);

    s_hi = hi; s_lo = lo; s_fl = flags;
    run(2'd3, 32'd5, 32'd7);
    chk("R9 no done", r_done, 0); chk("R9 lo kept", r_lo, s_lo);
    chk("R9 hi kept", r_hi, s_hi); chk("R9 flags kept", r_fl, s_fl);

    for (int i = 0; i < 40; i++) begin
      logic [1:0] o;
      logic [W-1:0] x, y;
      o = 2'($urandom_range(0, 2));
      x = (i % 4 == 0) ? 32'h80000000 : $urandom;
      y = (i % 5 == 0) ? 32'h7fffffff : $urandom;
      run(o, x, y);
      s_hi = r_hi; s_lo = r_lo; s_fl = r_fl;
      run(o, y, x);
      chk("R7 swap lo", r_lo, s_lo);
      chk("R7 swap hi", r_hi, s_hi);
      chk("R7 swap flags", r_fl, s_fl);
    end

    @(negedge clk); start = 1; op = 2'd0; a = 32'd3; b = 32'd5;
    @(negedge clk); op = 2'd1; a = 32'hffffffff; b = 32'd7;
    @(negedge clk); start = 0;
    chk("R12 first done", done, 1); chk("R12 first lo", lo, 15);
    @(negedge clk);
    chk("R12 second done", done, 1); chk("R12 second lo", lo, 32'hfffffff9);
    @(negedge clk);
    chk("R12 done drops", done, 0);

    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      start = ($urandom % 3) != 0; op = 2'($urandom); a = $urandom; b = $urandom;
    end
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule